// File: doc/BRIEF.md
# Ethernet PHY LED controller

This block turns the live state of an Ethernet PHY into the drive levels of a small row of status LEDs. Each LED owns a configuration of four small fields: a condition that lights it steadily, a condition that makes it blink quickly, a condition that makes it blink slowly, and a mask of traffic events. A matching traffic event blanks the LED for a fixed stretch of time. The conditions come from link speed and chip state.

Two global blink clocks are derived from the system clock, and each one has a selectable rate between 2 and 16 Hz. On top of the per-LED logic there are two chip-wide display modes. The first flashes every LED together. The second walks a single lit LED along the row. A third chip-state condition can suppress both modes.

Configuration arrives as byte writes on a small address/data port. Address 0 holds the blink rates and the suppress condition. Address 1 holds the two chip-wide mode conditions. Addresses 2+2i and 3+2i hold the two bytes of LED i.

Top module: `phy_led_ctrl`

## Requirements
- R1: After reset the configuration is: address 0 = 0xC5, address 1 = 0x67, LED0 = 0x70/0x03, LED1 = 0x20/0x00, LED2 = 0x40/0x00, LED3 = 0x40/0x20 (high byte / low byte). Both blink outputs start dark.
- R2: The 4-bit condition code selects:
  - 0: never
  - 1: link at 10
  - 2: link at 100
  - 3: link at 10 or 100
  - 4: link at 1000
  - 5: link at 10 or 1000
  - 6: link at 100 or 1000
  - 7: link at any of the three speeds
  - 8: powered down
  - 9: EEE
  - 10: auto-negotiation
  - 11: self-test
  - 12: cable diagnostics
  - 13 to 15: never

  The speed input encodes 0 = 10, 1 = 100 and 2 = 1000. A value of 3 matches no speed.
- R3: An LED whose steady field (high byte bits 7:4) matches the current state is lit, and otherwise it is dark, when no other source applies.
- R4: The fast blink has a 50% duty cycle. Its half period is CLK_HZ/(4<<code) cycles, with the code in address 0 bits 7:6. The fast field is high byte bits 3:0.
- R5: The slow blink behaves the same way, with the code in address 0 bits 5:4. The slow field is low byte bits 7:4.
- R6: Per LED, the first source that applies wins, in this order: event blanking (dark), fast blink, slow blink, steady on, off.
- R7: Low byte bit 0 masks TX activity, bit 1 masks RX activity and bit 2 masks collision. A masked event blanks the LED for exactly CLK_HZ*PULSE_MS/1000 cycles, starting in the cycle after the event. Unmasked events have no effect.
- R8: The 3-bit condition code selects:
  - 0: never
  - 1: link up
  - 2: powered down
  - 3: EEE
  - 4: auto-negotiation
  - 5: self-test
  - 6: cable diagnostics
  - 7: test mode

  When the condition in address 1 bits 2:0 holds, every LED shows the slow blink together.
- R9: When the condition in address 0 bits 2:0 holds, both chip-wide modes are suppressed and the per-LED logic drives the LEDs.
- R10: When the condition in address 1 bits 6:4 holds (and is not suppressed), exactly one LED is lit. The scan starts at LED0 and moves up one LED on each rising edge of the fast blink, wrapping from LED3 to LED0. The scan takes priority over the all-LED blink.
- R11: A write to an address above 9 changes no configuration.
- R12: A change of a blink rate code restarts that divider. The blink output is dark for exactly one new half period, counted from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W | Configuration byte address |
| cfg_wdata | input | 8 | Configuration byte |
| link_up | input | 1 | Link established |
| link_speed | input | 2 | 0 = 10, 1 = 100, 2 = 1000 |
| pwr_down | input | 1 | PHY powered down |
| eee_mode | input | 1 | Energy-efficient mode active |
| aneg_busy | input | 1 | Auto-negotiation running |
| selftest_busy | input | 1 | Analog self-test running |
| cable_diag_busy | input | 1 | Cable diagnostics running |
| test_mode | input | 1 | Test mode active |
| tx_evt | input | 1 | One-cycle transmit activity |
| rx_evt | input | 1 | One-cycle receive activity |
| col_evt | input | 1 | One-cycle collision |
| led_o | output | N_LEDS | LED drive, 1 = lit |

## Verification
Several sources can fall in the same cycle. A traffic event can arrive on an LED whose steady, fast or slow condition also holds. The scan condition can coincide with the all-LED blink condition. The suppress condition can coincide with both. The bench provokes each overlap directly: it configures one LED with steady, fast and slow conditions together, fires masked events on a steadily lit LED, and raises test mode, cable diagnostics and self-test together. It judges each outcome by which source's timing shows at the pins: blanking length, measured half period, one-hot walk order, or a row that stays dark.

// File: rtl/phy_led_pkg.sv
package phy_led_pkg;

    localparam logic [1:0] SPD_10   = 2'd0;
    localparam logic [1:0] SPD_100  = 2'd1;
    localparam logic [1:0] SPD_1000 = 2'd2;

    localparam logic [7:0] GLOB_HI_RST = 8'hC5;
    localparam logic [7:0] GLOB_LO_RST = 8'h67;

    typedef struct packed {
        logic       link_up;
        logic [1:0] speed;
        logic       pdown;
        logic       eee;
        logic       aneg;
        logic       abist;
        logic       cdiag;
        logic       test;
    } phy_state_t;

    typedef struct packed {
        logic [1:0] fast_rate;
        logic [1:0] slow_rate;
        logic [2:0] inhibit;
        logic [2:0] scan;
        logic [2:0] cblink;
    } glob_cfg_t;

    typedef struct packed {
        logic [3:0] steady;
        logic [3:0] fast;
        logic [3:0] slow;
        logic [3:0] pmask;
    } led_cfg_t;

    // high byte in [15:8], low byte in [7:0]
    function automatic logic [15:0] led_rst(int idx);
        case (idx)
            0:       return 16'h7003;
            1:       return 16'h2000;
            2:       return 16'h4000;
            3:       return 16'h4020;
            default: return 16'h0000;
        endcase
    endfunction

    function automatic logic cond3(logic [2:0] sel, phy_state_t s);
        case (sel)
            3'd1:    return s.link_up;
            3'd2:    return s.pdown;
            3'd3:    return s.eee;
            3'd4:    return s.aneg;
            3'd5:    return s.abist;
            3'd6:    return s.cdiag;
            3'd7:    return s.test;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic cond4(logic [3:0] sel, phy_state_t s);
        logic l10, l100, l1000;
        l10   = s.link_up && (s.speed == SPD_10);
        l100  = s.link_up && (s.speed == SPD_100);
        l1000 = s.link_up && (s.speed == SPD_1000);
        case (sel)
            4'h1:    return l10;
            4'h2:    return l100;
            4'h3:    return l10 | l100;
            4'h4:    return l1000;
            4'h5:    return l10 | l1000;
            4'h6:    return l100 | l1000;
            4'h7:    return l10 | l100 | l1000;
            4'h8:    return s.pdown;
            4'h9:    return s.eee;
            4'hA:    return s.aneg;
            4'hB:    return s.abist;
            4'hC:    return s.cdiag;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/led_blink_gen.sv
module led_blink_gen #(
    parameter int unsigned CLK_HZ   = 25_000_000,
    parameter logic [1:0]  RATE_RST = 2'd0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] rate,
    output logic       blk_o,
    output logic       rise_o
);
    localparam int unsigned HALF_MAX = CLK_HZ / 4;
    localparam int unsigned CW       = $clog2(HALF_MAX + 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] half_m1;
    logic [1:0]    rate_q;
    logic          blk_q;
    logic          restart;

    always_comb begin
        case (rate)
            2'd0:    half_m1 = CW'(CLK_HZ / 4 - 1);
            2'd1:    half_m1 = CW'(CLK_HZ / 8 - 1);
            2'd2:    half_m1 = CW'(CLK_HZ / 16 - 1);
            default: half_m1 = CW'(CLK_HZ / 32 - 1);
        endcase
    end

    assign restart = (rate != rate_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            blk_q  <= 1'b0;
            rate_q <= RATE_RST;
        end else begin
            rate_q <= rate;
            if (restart) begin
                cnt_q <= '0;
                blk_q <= 1'b0;
            end else if (cnt_q == half_m1) begin
                cnt_q <= '0;
                blk_q <= ~blk_q;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign blk_o  = blk_q;
    assign rise_o = !restart && (cnt_q == half_m1) && !blk_q;

    // R4 R5
    // blink_hold_chk: the level only moves at the end of a half period
    blink_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!restart && cnt_q != half_m1) |=> $stable(blk_q));

    // R12
    // blink_restart_chk: a rate change forces a dark restart
    blink_restart_chk: assert property (@(posedge clk) disable iff (rst)
        restart |=> (!blk_q && cnt_q == '0));

endmodule

// File: rtl/led_pulse_stretch.sv
module led_pulse_stretch #(
    parameter int unsigned LEN = 1_250_000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] ev,
    input  logic [2:0] mask,
    output logic       dark_o
);
    localparam int unsigned CW = $clog2(LEN + 1);

    logic [CW-1:0] cnt_q;
    logic          hit;

    assign hit = |(ev & mask);

    always_ff @(posedge clk) begin
        if (rst)               cnt_q <= '0;
        else if (hit)          cnt_q <= CW'(LEN);
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign dark_o = (cnt_q != '0);

    // R7
    // pulse_idle_chk: no blanking starts without a masked event
    pulse_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!hit && !dark_o) |=> !dark_o);

endmodule

// File: rtl/led_cfg_regs.sv
module led_cfg_regs
    import phy_led_pkg::*;
#(
    parameter int unsigned N_LEDS = 4,
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output glob_cfg_t         glob_o,
    output led_cfg_t          led_o [N_LEDS]
);
    glob_cfg_t glob_q;
    led_cfg_t  led_q [N_LEDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            glob_q.fast_rate <= GLOB_HI_RST[7:6];
            glob_q.slow_rate <= GLOB_HI_RST[5:4];
            glob_q.inhibit   <= GLOB_HI_RST[2:0];
            glob_q.scan      <= GLOB_LO_RST[6:4];
            glob_q.cblink    <= GLOB_LO_RST[2:0];
            for (int i = 0; i < int'(N_LEDS); i++) begin
                led_q[i] <= led_cfg_t'(led_rst(i));
            end
        end else if (we) begin
            if (addr == ADDR_W'(0)) begin
                glob_q.fast_rate <= wdata[7:6];
                glob_q.slow_rate <= wdata[5:4];
                glob_q.inhibit   <= wdata[2:0];
            end
            if (addr == ADDR_W'(1)) begin
                glob_q.scan   <= wdata[6:4];
                glob_q.cblink <= wdata[2:0];
            end
            for (int i = 0; i < int'(N_LEDS); i++) begin
                if (addr == ADDR_W'(2 + 2 * i)) begin
                    led_q[i].steady <= wdata[7:4];
                    led_q[i].fast   <= wdata[3:0];
                end
                if (addr == ADDR_W'(3 + 2 * i)) begin
                    led_q[i].slow  <= wdata[7:4];
                    led_q[i].pmask <= wdata[3:0];
                end
            end
        end
    end

    assign glob_o = glob_q;
    assign led_o  = led_q;

endmodule

// File: rtl/phy_led_ctrl.sv
module phy_led_ctrl
    import phy_led_pkg::*;
#(
    parameter int unsigned CLK_HZ   = 25_000_000,
    parameter int unsigned PULSE_MS = 50,
    parameter int unsigned N_LEDS   = 4,
    localparam int unsigned ADDR_W  = $clog2(2 + 2 * N_LEDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [7:0]        cfg_wdata,
    input  logic              link_up,
    input  logic [1:0]        link_speed,
    input  logic              pwr_down,
    input  logic              eee_mode,
    input  logic              aneg_busy,
    input  logic              selftest_busy,
    input  logic              cable_diag_busy,
    input  logic              test_mode,
    input  logic              tx_evt,
    input  logic              rx_evt,
    input  logic              col_evt,
    output logic [N_LEDS-1:0] led_o
);
    localparam longint      PULSE_LEN_L = longint'(CLK_HZ) * longint'(PULSE_MS) / 1000;
    localparam int unsigned PULSE_LEN   = (PULSE_LEN_L < 1) ? 1 : int'(PULSE_LEN_L);
    localparam int unsigned PW          = (N_LEDS > 1) ? $clog2(N_LEDS) : 1;

    glob_cfg_t   glob;
    led_cfg_t    lcfg [N_LEDS];
    phy_state_t  st;
    logic        fast_blk, fast_rise, slow_blk, slow_rise;
    logic [N_LEDS-1:0] dark, per_led, scan_map;
    logic        inhib, scan_on, cb_on;
    logic [PW-1:0] pos_q;

    assign st = '{link_up: link_up, speed: link_speed, pdown: pwr_down,
                  eee: eee_mode, aneg: aneg_busy, abist: selftest_busy,
                  cdiag: cable_diag_busy, test: test_mode};

    led_cfg_regs #(.N_LEDS(N_LEDS), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr),
        .wdata(cfg_wdata), .glob_o(glob), .led_o(lcfg)
    );

    led_blink_gen #(.CLK_HZ(CLK_HZ), .RATE_RST(GLOB_HI_RST[7:6])) u_fast (
        .clk(clk), .rst(rst), .rate(glob.fast_rate),
        .blk_o(fast_blk), .rise_o(fast_rise)
    );

    led_blink_gen #(.CLK_HZ(CLK_HZ), .RATE_RST(GLOB_HI_RST[5:4])) u_slow (
        .clk(clk), .rst(rst), .rate(glob.slow_rate),
        .blk_o(slow_blk), .rise_o(slow_rise)
    );

    for (genvar g = 0; g < int'(N_LEDS); g++) begin : g_led
        led_pulse_stretch #(.LEN(PULSE_LEN)) u_pulse (
            .clk(clk), .rst(rst), .ev({col_evt, rx_evt, tx_evt}),
            .mask(lcfg[g].pmask[2:0]), .dark_o(dark[g])
        );

        // R6
        // pulse_dark_chk: blanking overrides every per-LED source
        pulse_dark_chk: assert property (@(posedge clk) disable iff (rst)
            (!scan_on && !cb_on && dark[g]) |-> !led_o[g]);
    end

    always_comb begin
        for (int i = 0; i < int'(N_LEDS); i++) begin
            if (dark[i])                         per_led[i] = 1'b0;
            else if (cond4(lcfg[i].fast, st))    per_led[i] = fast_blk;
            else if (cond4(lcfg[i].slow, st))    per_led[i] = slow_blk;
            else if (cond4(lcfg[i].steady, st))  per_led[i] = 1'b1;
            else                                 per_led[i] = 1'b0;
        end
    end

    assign inhib   = cond3(glob.inhibit, st);
    assign scan_on = cond3(glob.scan, st) && !inhib;
    assign cb_on   = cond3(glob.cblink, st) && !inhib;

    always_ff @(posedge clk) begin
        if (rst || !scan_on)  pos_q <= '0;
        else if (fast_rise)   pos_q <= (pos_q == PW'(N_LEDS - 1)) ? '0 : pos_q + 1'b1;
    end

    assign scan_map = N_LEDS'(1) << pos_q;

    always_comb begin
        if (scan_on)     led_o = scan_map;
        else if (cb_on)  led_o = {N_LEDS{slow_blk}};
        else             led_o = per_led;
    end

    // R10
    // scan_step_chk: the lit LED only ever moves one place up
    scan_step_chk: assert property (@(posedge clk) disable iff (rst)
        (scan_on && $past(scan_on) && led_o != $past(led_o))
            |-> led_o == {$past(led_o[N_LEDS-2:0]), $past(led_o[N_LEDS-1])});

    // R10
    // scan_single_chk: a scan never lights more than one LED
    scan_single_chk: assert property (@(posedge clk) disable iff (rst)
        scan_on |-> $countones(led_o) == 1);

    // R8
    // cblink_sync_chk: all LEDs share one level during the chip-wide blink
    cblink_sync_chk: assert property (@(posedge clk) disable iff (rst)
        (cb_on && !scan_on) |-> (led_o == '0 || led_o == '1));

endmodule

// File: tb/phy_led_ctrl_tb.sv
module phy_led_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int CLK_HZ     = 320;
    localparam int PULSE_MS   = 50;
    localparam int PULSE_LEN  = CLK_HZ * PULSE_MS / 1000;

    logic       clk = 0;
    logic       rst = 1;
    logic       cfg_we = 0;
    logic [3:0] cfg_addr = 0;
    logic [7:0] cfg_wdata = 0;
    logic       link_up = 0;
    logic [1:0] link_speed = 0;
    logic       pwr_down = 0, eee_mode = 0, aneg_busy = 0, selftest_busy = 0;
    logic       cable_diag_busy = 0, test_mode = 0;
    logic       tx_evt = 0, rx_evt = 0, col_evt = 0;
    logic [3:0] led_o;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    phy_led_ctrl #(.CLK_HZ(CLK_HZ), .PULSE_MS(PULSE_MS), .N_LEDS(4)) u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .link_up(link_up), .link_speed(link_speed),
        .pwr_down(pwr_down), .eee_mode(eee_mode), .aneg_busy(aneg_busy),
        .selftest_busy(selftest_busy), .cable_diag_busy(cable_diag_busy),
        .test_mode(test_mode), .tx_evt(tx_evt), .rx_evt(rx_evt),
        .col_evt(col_evt), .led_o(led_o)
    );

    function automatic int half_of(int code);
        return CLK_HZ / (4 << code);
    endfunction

    function automatic bit exp_cond(logic [3:0] c, logic lu, logic [1:0] sp,
                                    logic pd, logic ee, logic an, logic ab, logic cd);
        bit at10, at100, at1000;
        at10   = lu && sp == 2'd0;
        at100  = lu && sp == 2'd1;
        at1000 = lu && sp == 2'd2;
        case (c)
            4'd1:  return at10;
            4'd2:  return at100;
            4'd3:  return at10 || at100;
            4'd4:  return at1000;
            4'd5:  return at10 || at1000;
            4'd6:  return at100 || at1000;
            4'd7:  return at10 || at100 || at1000;
            4'd8:  return pd;
            4'd9:  return ee;
            4'd10: return an;
            4'd11: return ab;
            4'd12: return cd;
            default: return 0;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 0;
    endtask

    // waits for a level change of one LED, then counts cycles to the next one
    task automatic measure_half(input int idx, output int h);
        logic v;
        int n;
        v = led_o[idx];
        n = 0;
        while (led_o[idx] == v && n < 1000) begin @(negedge clk); n++; end
        v = led_o[idx];
        h = 0;
        while (led_o[idx] == v && h < 1000) begin @(negedge clk); h++; end
    endtask

    task automatic count_low(input int idx, output int n);
        n = 0;
        while (!led_o[idx] && n < 1000) begin n++; @(negedge clk); end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int h, n, seed;
        logic [3:0] codes [4];
        logic [3:0] prev, expv;
        bit saw0, saw1, ok, first;
        int dwell;

        seed = $urandom(32'd7719);
        link_up = 1; link_speed = 2;
        repeat (5) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1: reset configuration seen at the pins
        chk(led_o == 4'b1101, "R1 reset leds at 1000", led_o, 4'b1101);
        link_speed = 1; #1;
        chk(led_o == 4'b0011, "R1 reset leds at 100", led_o, 4'b0011);
        link_speed = 2;
        @(negedge clk);

        // R7: masked TX and RX blank LED0, collision is masked out
        tx_evt = 1; @(negedge clk); tx_evt = 0;
        count_low(0, n);
        chk(n == PULSE_LEN, "R7 tx blanking length", n, PULSE_LEN);
        col_evt = 1; @(negedge clk); col_evt = 0;
        ok = 1;
        repeat (20) begin if (!led_o[0]) ok = 0; @(negedge clk); end
        chk(ok, "R7 unmasked collision ignored", ok, 1);
        rx_evt = 1; @(negedge clk); rx_evt = 0;
        count_low(0, n);
        // R6: blanking overrides steady on
        chk(n == PULSE_LEN, "R6 R7 rx blanking over steady", n, PULSE_LEN);

        // R4: fast blink on LED1
        wr(4'd4, 8'h07);
        measure_half(1, h);
        chk(h == half_of(3), "R4 fast half code3", h, half_of(3));
        // R12: rate change restarts dark
        wr(4'd0, 8'h45);
        @(negedge clk);
        count_low(1, n);
        chk(n == half_of(1), "R12 restart dark length", n, half_of(1));
        measure_half(1, h);
        chk(h == half_of(1), "R4 fast half code1", h, half_of(1));
        wr(4'd0, 8'hC5);

        // R6: fast beats slow and steady
        wr(4'd4, 8'h77); wr(4'd5, 8'h70);
        measure_half(1, h);
        chk(h == half_of(3), "R6 fast over slow", h, half_of(3));
        // R5: slow beats steady
        wr(4'd4, 8'h70);
        measure_half(1, h);
        chk(h == half_of(0), "R5 R6 slow half code0", h, half_of(0));
        wr(4'd0, 8'hE5);
        @(negedge clk);
        count_low(1, n);
        chk(n == half_of(2), "R5 slow restart code2", n, half_of(2));
        wr(4'd0, 8'hC5);

        // R11: out-of-range addresses ignored
        wr(4'd4, 8'h00); wr(4'd5, 8'h00);
        @(negedge clk);
        chk(led_o == 4'b1101, "R11 baseline", led_o, 4'b1101);
        wr(4'd12, 8'hFF); wr(4'd15, 8'hFF); wr(4'd10, 8'hFF);
        @(negedge clk);
        chk(led_o == 4'b1101, "R11 ignored writes", led_o, 4'b1101);
        wr(4'd4, 8'h40);
        @(negedge clk);
        chk(led_o == 4'b1111, "R11 valid write", led_o, 4'b1111);

        // R2 R3: random steady codes against random state
        wr(4'd1, 8'h00);
        for (int r = 0; r < 8; r++) begin
            for (int i = 0; i < 4; i++) begin
                codes[i] = 4'($urandom % 16);
                if (r == 0) codes[i] = 4'(13 + (i % 3));
                wr(4'(2 + 2 * i), {codes[i], 4'h0});
                wr(4'(3 + 2 * i), 8'h00);
            end
            for (int k = 0; k < 40; k++) begin
                @(negedge clk);
                link_up = 1'($urandom); link_speed = 2'($urandom);
                pwr_down = 1'($urandom); eee_mode = 1'($urandom);
                aneg_busy = 1'($urandom); selftest_busy = 1'($urandom);
                cable_diag_busy = 1'($urandom); test_mode = 1'($urandom);
                tx_evt = 1'($urandom); rx_evt = 1'($urandom); col_evt = 1'($urandom);
                #1;
                for (int i = 0; i < 4; i++)
                    expv[i] = exp_cond(codes[i], link_up, link_speed, pwr_down,
                                       eee_mode, aneg_busy, selftest_busy, cable_diag_busy);
                chk(led_o == expv, "R2 R3 steady decode", led_o, expv);
            end
        end
        tx_evt = 0; rx_evt = 0; col_evt = 0;
        link_up = 0; pwr_down = 0; eee_mode = 0; aneg_busy = 0;
        selftest_busy = 0; cable_diag_busy = 0; test_mode = 0;
        for (int i = 0; i < 4; i++) begin
            wr(4'(2 + 2 * i), 8'h00); wr(4'(3 + 2 * i), 8'h00);
        end
        wr(4'd1, 8'h67);

        // R8: chip-wide blink on test mode
        test_mode = 1;
        ok = 1; saw0 = 0; saw1 = 0;
        repeat (200) begin
            @(negedge clk);
            if (led_o != 4'h0 && led_o != 4'hF) ok = 0;
            if (led_o == 4'h0) saw0 = 1;
            if (led_o == 4'hF) saw1 = 1;
        end
        chk(ok && saw0 && saw1, "R8 all LEDs blink together", led_o, 4'hF);
        measure_half(3, h);
        chk(h == half_of(0), "R8 chip blink at slow rate", h, half_of(0));

        // R9: self-test suppresses both chip-wide modes
        selftest_busy = 1;
        ok = 1;
        repeat (100) begin @(negedge clk); if (led_o != 4'h0) ok = 0; end
        chk(ok, "R9 chip blink suppressed", led_o, 0);
        cable_diag_busy = 1;
        ok = 1;
        repeat (100) begin @(negedge clk); if (led_o != 4'h0) ok = 0; end
        chk(ok, "R9 scan suppressed", led_o, 0);

        // R10: walking LED, taking priority over the chip blink
        @(negedge clk);
        selftest_busy = 0; #1;
        chk(led_o == 4'b0001, "R10 scan starts at LED0", led_o, 4'b0001);
        prev = led_o; dwell = 1; first = 1;
        repeat (200) begin
            @(negedge clk);
            if (led_o != prev) begin
                chk(led_o == {prev[2:0], prev[3]}, "R10 scan order", led_o, {prev[2:0], prev[3]});
                if (!first)
                    chk(dwell == 2 * half_of(3), "R10 scan step time", dwell, 2 * half_of(3));
                first = 0;
                dwell = 1;
                prev = led_o;
            end else begin
                dwell++;
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule